// File: doc/BRIEF.md
# Bidirectional Walking-One LED Register

This block keeps a register with exactly one set bit and moves that bit by one position each time an advance event occurs. A direction input picks the way: toward higher bit indices or toward lower ones. A bit that leaves one end of the register re-enters at the other end. The register value drives the LED outputs directly.

An advance event comes from one of two sources, and a select input picks which one is used. The first source is a push-button input. The block passes it through a synchroniser chain and turns each low-to-high change of the synchronised level into a single-cycle enable. The second source is a free-running divider that gives a single-cycle tick once every `TICK_DIV` clocks. The default count gives roughly 1.5 Hz from a 50 MHz clock. Everything runs on one clock, and no derived clock drives any flop. A synchronous reset reloads the pattern with only bit 0 set, and it wins over an advance event in the same cycle.

Top module: `walk_led_top`

## Requirements
- R1: With `dir_i`=1, each advance moves the set bit from index i to index i+1, and a set bit at the top index moves to index 0.
- R2: With `dir_i`=0, each advance moves the set bit from index i to index i-1, and a set bit at index 0 moves to the top index.
- R3: A clock edge that samples `rst_i`=1 loads the value 1 (only bit 0 set), even when an advance is pending in that cycle. It also clears the synchroniser and the divider counter.
- R4: From the first reset onward, exactly one bit of `led_o` is 1 in every cycle.
- R5: `btn_i` passes through `SYNC_STAGES` flops (default 2). A 0-to-1 change at the last stage advances the register once, on the second edge after the edge that first samples the high level. Holding the button, or releasing it, gives no further advance.
- R6: With `auto_sel_i`=1, the divider counts 0..`TICK_DIV`-1 from reset and then wraps. The register advances on the edge that ends each count of `TICK_DIV`-1, which is every `TICK_DIV` clocks, with the first advance `TICK_DIV` edges after reset.
- R7: With `auto_sel_i`=0, ticks have no effect. With `auto_sel_i`=1, button edges have no effect. The divider keeps running whatever the select value is.
- R8: `led_o` equals the pattern register bit for bit, with bit i on `led_o[i]`.
- R9: In a cycle with no selected advance event and no reset, the pattern holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw push-button level, asynchronous to clk |
| dir_i | input | 1 | 1: move toward higher index, 0: toward lower index |
| auto_sel_i | input | 1 | 0: button advances, 1: divider tick advances |
| led_o | output | WIDTH | Pattern register value |

## Verification
The bench walks the bit past both ends of the register in both directions. A design that shifted in a zero would go dark, and one with the wrap wired to the wrong end would light two LEDs or skip a position. It holds the button high for many cycles and changes the select while the other source is active. A level-sensitive or wrongly selected advance would then step the pattern repeatedly or at the wrong time. It also applies reset in cycles that carry a pending tick, and it checks the exact cycle of each advance after the synchroniser delay and after each divider wrap. An off-by-one in the divider's terminal count would shift every later tick, and a reset without priority would leave the pattern one position off.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic {
    SRC_BUTTON = 1'b0,
    SRC_TICK   = 1'b1
  } adv_src_e;

  typedef enum logic {
    MOVE_DOWN = 1'b0,
    MOVE_UP   = 1'b1
  } move_dir_e;

  // Width of a counter able to hold 0..limit-1 (at least one bit)
  function automatic int unsigned count_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/walk_sync_edge.sv
module walk_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic level_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   lvl_new;
  logic                   lvl_old;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst_i) chain <= '0;
        else       chain <= level_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst_i) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], level_i};
      end
    end
  endgenerate

  assign lvl_new = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst_i) lvl_old <= 1'b0;
    else       lvl_old <= lvl_new;
  end

  assign rise_o = lvl_new & ~lvl_old;

  // R5: a rising edge is a single-cycle pulse
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst_i)
    rise_o |=> !rise_o)
    else $error("rise pulse longer than one cycle");

endmodule

// File: rtl/walk_tick_div.sv
module walk_tick_div #(
  parameter int unsigned TICK_DIV = 2**25
) (
  input  logic clk,
  input  logic rst_i,
  output logic tick_o
);
  import walk_pkg::*;

  localparam int unsigned CW = count_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] count_q;

  assign tick_o = (count_q == LAST);

  always_ff @(posedge clk) begin
    if (rst_i)       count_q <= '0;
    else if (tick_o) count_q <= '0;
    else             count_q <= count_q + 1'b1;
  end

  // R6: counter never leaves its range
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst_i)
    count_q <= LAST)
    else $error("divider count out of range");

  // R6: after a tick the count restarts at zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst_i)
    tick_o |=> (count_q == '0))
    else $error("divider did not wrap");

endmodule

// File: rtl/walk_ring.sv
module walk_ring #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic             dir_i,
  output logic [WIDTH-1:0] pattern_o
);
  import walk_pkg::*;

  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  function automatic logic [WIDTH-1:0] turn(input logic [WIDTH-1:0] p,
                                            input move_dir_e d);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      if (d == MOVE_UP) r[(i + 1) % WIDTH] = p[i];
      else              r[i] = p[(i + 1) % WIDTH];
    end
    return r;
  endfunction

  logic [WIDTH-1:0] pat_q;

  always_ff @(posedge clk) begin
    if (rst_i)       pat_q <= SEED;
    else if (step_i) pat_q <= turn(pat_q, move_dir_e'(dir_i));
  end

  assign pattern_o = pat_q;

  // R3: the first cycle after reset shows the seed
  assert_reset_seed_R3: assert property (@(posedge clk) disable iff (rst_i)
    $fell(rst_i) |-> (pat_q == SEED))
    else $error("reset did not load seed");

  // R4: single set bit
  assert_single_hot_R4: assert property (@(posedge clk) disable iff (rst_i)
    $countones(pat_q) == 1)
    else $error("pattern not one-hot");

  // R9: no step means no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst_i)
    !step_i |=> $stable(pat_q))
    else $error("pattern changed without step");

  // R1: top bit wraps to bit 0 when moving up
  assert_wrap_up_R1: assert property (@(posedge clk) disable iff (rst_i)
    (step_i && dir_i && pat_q[WIDTH-1]) |=> pat_q[0])
    else $error("upward wrap lost");

  // R2: bit 0 wraps to the top bit when moving down
  assert_wrap_down_R2: assert property (@(posedge clk) disable iff (rst_i)
    (step_i && !dir_i && pat_q[0]) |=> pat_q[WIDTH-1])
    else $error("downward wrap lost");

endmodule

// File: rtl/walk_led_top.sv
module walk_led_top #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 2**25
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             btn_i,
  input  logic             dir_i,
  input  logic             auto_sel_i,
  output logic [WIDTH-1:0] led_o
);
  import walk_pkg::*;

  logic btn_rise;
  logic div_tick;
  logic adv_step;

  walk_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_i   (rst_i),
    .level_i (btn_i),
    .rise_o  (btn_rise)
  );

  walk_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk    (clk),
    .rst_i  (rst_i),
    .tick_o (div_tick)
  );

  assign adv_step = (adv_src_e'(auto_sel_i) == SRC_TICK) ? div_tick : btn_rise;

  walk_ring #(.WIDTH(WIDTH)) u_ring (
    .clk       (clk),
    .rst_i     (rst_i),
    .step_i    (adv_step),
    .dir_i     (dir_i),
    .pattern_o (led_o)
  );

  // R7: in button mode a tick alone does not move the LEDs
  assert_tick_ignored_R7: assert property (@(posedge clk) disable iff (rst_i)
    (!auto_sel_i && div_tick && !btn_rise) |=> $stable(led_o))
    else $error("tick moved pattern in button mode");

  // R7: in tick mode a button edge alone does not move the LEDs
  assert_button_ignored_R7: assert property (@(posedge clk) disable iff (rst_i)
    (auto_sel_i && btn_rise && !div_tick) |=> $stable(led_o))
    else $error("button moved pattern in tick mode");

endmodule

// File: tb/walk_led_top_tb.sv
module walk_led_top_tb;

  localparam int W   = 8;
  localparam int SS  = 2;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic btn_i = 1'b0;
  logic dir_i = 1'b1;
  logic auto_sel_i = 1'b0;
  logic [W-1:0] led_o;

  int compared = 0;
  int mismatched = 0;
  string tag = "R3";
  bit done = 1'b0;

  always #10 clk = ~clk;

  walk_led_top #(.WIDTH(W), .SYNC_STAGES(SS), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_i(rst_i), .btn_i(btn_i), .dir_i(dir_i),
    .auto_sel_i(auto_sel_i), .led_o(led_o)
  );

  // Reference model: history of sampled button levels, an integer
  // position of the lit LED and a cycle counter for the tick.
  bit hist[$];
  int pos = 0;
  int since = 0;

  always @(posedge clk) begin
    bit edge_seen;
    bit tick_now;
    if (rst_i) begin
      hist.delete();
      for (int i = 0; i <= SS; i++) hist.push_back(1'b0);
      pos = 0;
      since = 0;
    end else begin
      edge_seen = hist[SS-1] && !hist[SS];
      tick_now  = (since == DIV - 1);
      if (auto_sel_i ? tick_now : edge_seen)
        pos = dir_i ? (pos + 1) % W : (pos + W - 1) % W;
      since = tick_now ? 0 : since + 1;
      hist.push_front(btn_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [W-1:0] exp_v;
    if (!done) begin
      exp_v = '0;
      exp_v[pos] = 1'b1;
      compared++;
      if (led_o !== exp_v) begin
        mismatched++;
        $display("FAIL R8/%s: led_o=%h expected=%h at %0t", tag, led_o, exp_v, $time);
      end
      compared++;
      if ($countones(led_o) != 1) begin
        mismatched++;
        $display("FAIL R4: led_o=%h ones=%0d expected 1", led_o, $countones(led_o));
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int hi, input int lo);
    btn_i = 1'b1; cycles(hi);
    btn_i = 1'b0; cycles(lo);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    cycles(3);
    rst_i = 1'b0;
    tag = "R3"; cycles(2);
    // R1 R5: upward presses, including wrap from the top bit
    tag = "R1_R5"; dir_i = 1'b1;
    for (int k = 0; k < 10; k++) press(4, 4);
    // R5: a long hold gives one step only
    tag = "R5_hold"; press(25, 6);
    // R2: downward presses, including wrap from bit 0
    tag = "R2_R5"; dir_i = 1'b0;
    for (int k = 0; k < 11; k++) press(3, 5);
    // R6 R7: tick mode, button activity ignored
    tag = "R6_R7"; auto_sel_i = 1'b1;
    for (int k = 0; k < 8; k++) press(3, 4);
    dir_i = 1'b1; cycles(45);
    // R7 R9: button mode, ticks ignored, no presses
    tag = "R7_R9"; auto_sel_i = 1'b0; cycles(30);
    // R3: reset in several phases of the divider, tick mode
    tag = "R3_prio"; auto_sel_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cycles(k + 3);
      rst_i = 1'b1; cycles(1);
      rst_i = 1'b0;
    end
    cycles(DIV * 3);
    // R3: reset while a button edge is pending
    tag = "R3_btn"; auto_sel_i = 1'b0; btn_i = 1'b1; cycles(SS);
    rst_i = 1'b1; cycles(1); rst_i = 1'b0; cycles(8); btn_i = 1'b0; cycles(4);
    finish_run();
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

endmodule